// File: doc/BRIEF.md
# Condition-Test Fail-First Element Loop

This block steps a two-operand operation, an add, across the elements of a vector, one element per clock cycle, in program order from element 0. For every active element it derives a 4-bit condition field (less-than, greater-than, equal-to-zero and a summary bit that is always zero). It then compares one chosen bit of that field against an expected value. The outcome of that comparison steers the element's writes to a register-file write port and a condition-field write port.

Two policies are available. In fail-first mode the first element whose test fails stops the loop. That element and every later one are dropped, and the reported vector length becomes the failing element's index, which can be zero. In predicated-result mode the loop always covers the full length. A failing element loses only its result write and keeps its condition field. A condition-only flag turns the operation into a compare: results are never written and the equal-to-zero bit is the bit tested. Masked-out elements are skipped. A zeroing flag makes skipped or rejected elements write zero instead.

A start pulse latches the whole configuration. Operands are fetched combinationally through an element index output. A one-cycle done pulse reports the final vector length.

Top module: `cond_ff_loop`

## Requirements
- R1: After reset, done, rf_we and cr_we are low and vl_out is zero.
- R2: After an accepted start, element k is presented on elem_idx in the k-th cycle after the start edge. The cycles run in order from element 0 with no gaps. Any register write goes to address k, and any condition write goes to cr_base+k, modulo 2^CRAW.
- R3: The result is opa+opb modulo 2^DW. The condition field is cr_wdata[3]=lt (sign bit of the result set), cr_wdata[2]=gt (sign clear and result nonzero), cr_wdata[1]=eq (result zero), and cr_wdata[0]=0.
- R4: The test passes when cr_wdata[3-sel_bit] equals expect_bit. sel_bit 0 selects lt, 1 selects gt, 2 selects eq and 3 selects the always-zero bit.
- R5: In fail-first mode (ffirst_mode=1), the first active element i that fails produces no writes. No later element is processed, and vl_out becomes i. Each passing element before it writes its result when cond_only=0, and writes its condition field when rc_en or cond_only is set.
- R6: The vector length never grows and changes only through a failed test. Element 0 failing gives vl_out=0. A start with vl_in=0 produces no writes and a done pulse carrying zero.
- R7: In predicated-result mode (ffirst_mode=0), each active element writes its condition field when rc_en or cond_only is set, whatever the outcome. Its result is written only when the test passes. vl_out equals vl_in.
- R8: With cond_only=1, rf_we stays low. The eq bit is tested whatever sel_bit holds.
- R9: An element whose pred_mask bit is 0 writes no condition field and cannot fail the test. When zeroing=1 and cond_only=0, it writes zero to its register. Otherwise it writes nothing.
- R10: In predicated-result mode with zeroing=1 and cond_only=0, a failing active element writes zero to its register.
- R11: done rises for exactly one cycle per run. For a run of n processed elements it comes n+1 cycles after the start edge, and in the first cycle for vl_in=0.
- R12: With rc_en=0 and cond_only=0, cr_we stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; ignored while a run is in progress |
| vl_in | input | VLW | Vector length for the run (0..MAXVL) |
| pred_mask | input | MAXVL | Per-element enable, bit k for element k |
| cr_base | input | CRAW | Condition-field address of element 0 |
| sel_bit | input | 2 | Index of the tested condition bit |
| expect_bit | input | 1 | Value the tested bit must have to pass |
| ffirst_mode | input | 1 | 1 selects fail-first, 0 selects predicated-result |
| rc_en | input | 1 | Store condition fields |
| cond_only | input | 1 | Compare-only operation: no result writes, eq tested |
| zeroing | input | 1 | Write zero for skipped or rejected elements |
| elem_idx | output | IW | Element currently being processed |
| opa_in | input | DW | First operand of element elem_idx |
| opb_in | input | DW | Second operand of element elem_idx |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | IW | Register write element index |
| rf_wdata | output | DW | Register write data |
| cr_we | output | 1 | Condition-field write enable |
| cr_waddr | output | CRAW | Condition-field write address |
| cr_wdata | output | 4 | Condition field {lt, gt, eq, 0} |
| done | output | 1 | One-cycle end-of-run pulse |
| vl_out | output | VLW | Resulting vector length, valid with done and held afterwards |

## Verification
The bench goes after a failure in the middle of the vector, at element 0 and with a zero-length start. A design that truncated one element late, wrote the failing element, or never reached zero length would show a wrong vl_out or a stray write there. Masked elements whose sums would fail the test check that skipped elements neither stop the loop nor store a condition field. Predicated-result runs with zeroing check that a rejected element still stores its condition field while its register receives zero. Compare-only runs with sel_bit pointing away from eq, and sums that wrap into the sign bit, expose a design that tests the wrong bit or compares unsigned.

// File: rtl/cff_pkg.sv
package cff_pkg;
   typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_RUN = 1'b1} cff_state_e;

   typedef struct packed {
      logic lt;
      logic gt;
      logic eq;
      logic so;
   } cff_cr_t;
endpackage

// File: rtl/cff_cond_gen.sv
module cff_cond_gen #(
   parameter int DW         = 16,
   parameter bit SIGNED_CMP = 1'b1
) (
   input  logic [DW-1:0]   opa,
   input  logic [DW-1:0]   opb,
   output logic [DW-1:0]   res,
   output cff_pkg::cff_cr_t crf
);
   logic is_zero;
   logic is_neg;

   assign res     = opa + opb;
   assign is_zero = (res == '0);

   generate
      if (SIGNED_CMP) begin : g_signed
         assign is_neg = res[DW-1];
      end else begin : g_unsigned
         assign is_neg = 1'b0;
      end
   endgenerate

   always_comb begin
      crf.lt = is_neg;
      crf.gt = !is_neg && !is_zero;
      crf.eq = is_zero;
      crf.so = 1'b0;
   end
endmodule

// File: rtl/cff_bit_test.sv
module cff_bit_test (
   input  cff_pkg::cff_cr_t crf,
   input  logic [1:0]       sel,
   input  logic             expect_val,
   input  logic             force_eq,
   output logic             pass
);
   logic [1:0] sel_eff;
   logic [3:0] field;
   logic       picked;

   assign field   = crf;
   assign sel_eff = force_eq ? 2'd2 : sel;
   assign picked  = field[2'd3 - sel_eff];
   assign pass    = (picked == expect_val);
endmodule

// File: rtl/cff_seq.sv
module cff_seq #(
   parameter int MAXVL = 16,
   parameter int IW    = $clog2(MAXVL),
   parameter int VLW   = $clog2(MAXVL + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [VLW-1:0] vl_in,
   input  logic           stop,
   output logic           accept,
   output logic           running,
   output logic [IW-1:0]  idx,
   output logic           done,
   output logic [VLW-1:0] vl_out
);
   import cff_pkg::*;

   cff_state_e     st_q;
   logic [IW-1:0]  idx_q;
   logic [VLW-1:0] vl_q;
   logic [VLW-1:0] vlo_q;
   logic           done_q;
   logic           last;

   assign last    = (VLW'(idx_q) + VLW'(1)) == vl_q;
   assign running = (st_q == ST_RUN);
   assign accept  = (st_q == ST_IDLE) && start;
   assign idx     = idx_q;
   assign done    = done_q;
   assign vl_out  = vlo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         idx_q  <= '0;
         vl_q   <= '0;
         vlo_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (start) begin
                  vl_q  <= vl_in;
                  idx_q <= '0;
                  if (vl_in == '0) begin
                     done_q <= 1'b1;
                     vlo_q  <= '0;
                  end else begin
                     st_q <= ST_RUN;
                  end
               end
            end
            ST_RUN: begin
               if (stop) begin
                  done_q <= 1'b1;
                  vlo_q  <= VLW'(idx_q);
                  st_q   <= ST_IDLE;
               end else if (last) begin
                  done_q <= 1'b1;
                  vlo_q  <= vl_q;
                  st_q   <= ST_IDLE;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // R2
   idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (running && $past(running)) |-> (idx_q == $past(idx_q) + 1'b1));

   // R6
   vl_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (vlo_q <= vl_q));
endmodule

// File: rtl/cond_ff_loop.sv
module cond_ff_loop #(
   parameter int DW         = 16,
   parameter int MAXVL      = 16,
   parameter int CRAW       = 6,
   parameter bit SIGNED_CMP = 1'b1,
   localparam int IW        = $clog2(MAXVL),
   localparam int VLW       = $clog2(MAXVL + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [VLW-1:0]  vl_in,
   input  logic [MAXVL-1:0] pred_mask,
   input  logic [CRAW-1:0] cr_base,
   input  logic [1:0]      sel_bit,
   input  logic            expect_bit,
   input  logic            ffirst_mode,
   input  logic            rc_en,
   input  logic            cond_only,
   input  logic            zeroing,
   output logic [IW-1:0]   elem_idx,
   input  logic [DW-1:0]   opa_in,
   input  logic [DW-1:0]   opb_in,
   output logic            rf_we,
   output logic [IW-1:0]   rf_waddr,
   output logic [DW-1:0]   rf_wdata,
   output logic            cr_we,
   output logic [CRAW-1:0] cr_waddr,
   output logic [3:0]      cr_wdata,
   output logic            done,
   output logic [VLW-1:0]  vl_out
);
   import cff_pkg::*;

   generate
      if (DW < 2) begin : g_bad_dw
         $error("cond_ff_loop: DW must be at least 2");
      end
      if (MAXVL < 2) begin : g_bad_maxvl
         $error("cond_ff_loop: MAXVL must be at least 2");
      end
      if ((1 << CRAW) < MAXVL) begin : g_bad_craw
         $error("cond_ff_loop: CRAW too narrow for MAXVL");
      end
   endgenerate

   logic [MAXVL-1:0] mask_q;
   logic [CRAW-1:0]  base_q;
   logic [1:0]       sel_q;
   logic             exp_q, ff_q, rc_q, co_q, z_q;
   logic [VLW-1:0]   vlin_q;

   logic             accept, running, stop, pass;
   logic [IW-1:0]    idx;
   logic [DW-1:0]    res;
   cff_cr_t          crf;
   logic             active, fail, wr_res, wr_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         base_q <= '0;
         sel_q  <= '0;
         exp_q  <= 1'b0;
         ff_q   <= 1'b0;
         rc_q   <= 1'b0;
         co_q   <= 1'b0;
         z_q    <= 1'b0;
         vlin_q <= '0;
      end else if (accept) begin
         mask_q <= pred_mask;
         base_q <= cr_base;
         sel_q  <= sel_bit;
         exp_q  <= expect_bit;
         ff_q   <= ffirst_mode;
         rc_q   <= rc_en;
         co_q   <= cond_only;
         z_q    <= zeroing;
         vlin_q <= vl_in;
      end
   end

   cff_seq #(.MAXVL(MAXVL), .IW(IW), .VLW(VLW)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .vl_in   (vl_in),
      .stop    (stop),
      .accept  (accept),
      .running (running),
      .idx     (idx),
      .done    (done),
      .vl_out  (vl_out)
   );

   cff_cond_gen #(.DW(DW), .SIGNED_CMP(SIGNED_CMP)) u_cond (
      .opa (opa_in),
      .opb (opb_in),
      .res (res),
      .crf (crf)
   );

   cff_bit_test u_test (
      .crf        (crf),
      .sel        (sel_q),
      .expect_val (exp_q),
      .force_eq   (co_q),
      .pass       (pass)
   );

   assign elem_idx = idx;
   assign active   = running && mask_q[idx];
   assign fail     = active && !pass;
   assign stop     = ff_q && fail;

   assign wr_res   = active && pass && !co_q;
   assign wr_zero  = running && !co_q && z_q && (!mask_q[idx] || (fail && !ff_q));

   assign rf_we    = wr_res || wr_zero;
   assign rf_waddr = idx;
   assign rf_wdata = wr_res ? res : '0;

   assign cr_we    = active && (rc_q || co_q) && !stop;
   assign cr_waddr = base_q + CRAW'(idx);
   assign cr_wdata = crf;

   // R8
   co_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (running && co_q) |-> !rf_we);

   // R7
   pr_vl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !ff_q) |-> (vl_out == vlin_q));

   // R5
   ff_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> !running);

   // R9
   mask_nocr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !mask_q[idx]) |-> !cr_we);

   // R12
   rc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !rc_q && !co_q) |-> !cr_we);
endmodule

// File: tb/cond_ff_loop_test.sv
module cond_ff_loop_test;
   localparam int CLK_PERIOD = 10;
   localparam int DW    = 16;
   localparam int MAXVL = 16;
   localparam int CRAW  = 6;
   localparam int IW    = 4;
   localparam int VLW   = 5;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [VLW-1:0]  vl_in = '0;
   logic [MAXVL-1:0] pred_mask = '0;
   logic [CRAW-1:0] cr_base = '0;
   logic [1:0]      sel_bit = '0;
   logic            expect_bit = 1'b0;
   logic            ffirst_mode = 1'b0;
   logic            rc_en = 1'b0;
   logic            cond_only = 1'b0;
   logic            zeroing = 1'b0;
   logic [IW-1:0]   elem_idx;
   logic [DW-1:0]   opa_in, opb_in;
   logic            rf_we, cr_we, done;
   logic [IW-1:0]   rf_waddr;
   logic [DW-1:0]   rf_wdata;
   logic [CRAW-1:0] cr_waddr;
   logic [3:0]      cr_wdata;
   logic [VLW-1:0]  vl_out;

   logic [DW-1:0] a_mem [MAXVL];
   logic [DW-1:0] b_mem [MAXVL];

   assign opa_in = a_mem[elem_idx];
   assign opb_in = b_mem[elem_idx];

   int vectors = 0;
   int miscompares = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cond_ff_loop uut (
      .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in),
      .pred_mask(pred_mask), .cr_base(cr_base), .sel_bit(sel_bit),
      .expect_bit(expect_bit), .ffirst_mode(ffirst_mode), .rc_en(rc_en),
      .cond_only(cond_only), .zeroing(zeroing), .elem_idx(elem_idx),
      .opa_in(opa_in), .opb_in(opb_in), .rf_we(rf_we), .rf_waddr(rf_waddr),
      .rf_wdata(rf_wdata), .cr_we(cr_we), .cr_waddr(cr_waddr),
      .cr_wdata(cr_wdata), .done(done), .vl_out(vl_out)
   );

   // observation log filled at falling edges
   bit              log_on = 1'b0;
   int              cyc, done_cnt, done_cyc, order_bad;
   logic [VLW-1:0]  vl_got;
   bit              rf_w [MAXVL];
   logic [DW-1:0]   rf_d [MAXVL];
   bit              cr_w [MAXVL];
   logic [3:0]      cr_d [MAXVL];
   logic [CRAW-1:0] cr_off;

   assign cr_off = cr_waddr - cr_base;

   always @(negedge clk) begin
      if (log_on) begin
         cyc++;
         if (rf_we) begin
            if (int'(rf_waddr) != cyc - 1) order_bad++;
            rf_w[rf_waddr] = 1'b1;
            rf_d[rf_waddr] = rf_wdata;
         end
         if (cr_we) begin
            if (int'(cr_off) != cyc - 1 || int'(cr_off) >= MAXVL) order_bad++;
            else begin
               cr_w[cr_off] = 1'b1;
               cr_d[cr_off] = cr_wdata;
            end
         end
         if (done) begin
            done_cnt++;
            done_cyc = cyc;
            vl_got   = vl_out;
         end
      end
   end

   task automatic chk(bit ok, string tag, int act, int exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
   endtask

   // apply one configuration, observe the run and compare against a model of R2..R12
   task automatic run_case(string tag, int vl, logic [MAXVL-1:0] mask, int sel,
                           bit ex, bit ff, bit rc, bit co, bit z, int base);
      bit            e_rfw [MAXVL];
      logic [DW-1:0] e_rfd [MAXVL];
      bit            e_crw [MAXVL];
      logic [3:0]    e_crd [MAXVL];
      int            e_vl, e_n;
      bit            stopped;
      @(negedge clk);
      #1;
      vl_in = VLW'(vl); pred_mask = mask; sel_bit = 2'(sel); expect_bit = ex;
      ffirst_mode = ff; rc_en = rc; cond_only = co; zeroing = z;
      cr_base = CRAW'(base);
      for (int i = 0; i < MAXVL; i++) begin
         rf_w[i] = 1'b0; rf_d[i] = '0; cr_w[i] = 1'b0; cr_d[i] = '0;
         e_rfw[i] = 1'b0; e_rfd[i] = '0; e_crw[i] = 1'b0; e_crd[i] = '0;
      end
      cyc = 0; done_cnt = 0; done_cyc = -1; order_bad = 0; vl_got = '0;
      log_on = 1'b1;
      start = 1'b1;
      @(negedge clk);
      #1;
      start = 1'b0;
      for (int w = 0; w < 64 && done_cnt == 0; w++) begin
         @(negedge clk);
         #1;
      end
      repeat (3) @(negedge clk);
      #1;
      log_on = 1'b0;

      // model
      e_vl = vl; e_n = vl; stopped = 1'b0;
      for (int i = 0; i < vl; i++) begin
         logic [DW-1:0] r;
         logic [3:0]    crv;
         logic          lt, gt, eq, sb;
         bit            ok;
         if (stopped) continue;
         if (!mask[i]) begin
            if (z && !co) begin e_rfw[i] = 1'b1; e_rfd[i] = '0; end
            continue;
         end
         r   = a_mem[i] + b_mem[i];
         lt  = r[DW-1];
         eq  = (r == '0);
         gt  = !lt && !eq;
         crv = {lt, gt, eq, 1'b0};
         sb  = co ? eq : crv[3 - sel];
         ok  = (sb == ex);
         if (ff && !ok) begin
            e_vl = i; e_n = i + 1; stopped = 1'b1;
            continue;
         end
         if (rc || co) begin e_crw[i] = 1'b1; e_crd[i] = crv; end
         if (!co) begin
            if (ok) begin e_rfw[i] = 1'b1; e_rfd[i] = r; end
            else if (z) begin e_rfw[i] = 1'b1; e_rfd[i] = '0; end
         end
      end

      chk(done_cnt == 1, {tag, " R11 done pulse count"}, done_cnt, 1);
      chk(done_cyc == e_n + 1, {tag, " R11 done cycle"}, done_cyc, e_n + 1);
      chk(int'(vl_got) == e_vl, {tag, " R5 R6 R7 vl_out"}, int'(vl_got), e_vl);
      chk(order_bad == 0, {tag, " R2 write address order"}, order_bad, 0);
      for (int i = 0; i < MAXVL; i++) begin
         chk(rf_w[i] == e_rfw[i], $sformatf("%s R5 R7 R9 rf_we elem %0d", tag, i),
             int'(rf_w[i]), int'(e_rfw[i]));
         if (e_rfw[i] && rf_w[i])
            chk(rf_d[i] == e_rfd[i], $sformatf("%s R3 R10 rf_wdata elem %0d", tag, i),
                int'(rf_d[i]), int'(e_rfd[i]));
         chk(cr_w[i] == e_crw[i], $sformatf("%s R7 R12 cr_we elem %0d", tag, i),
             int'(cr_w[i]), int'(e_crw[i]));
         if (e_crw[i] && cr_w[i])
            chk(cr_d[i] == e_crd[i], $sformatf("%s R3 R4 cr_wdata elem %0d", tag, i),
                int'(cr_d[i]), int'(e_crd[i]));
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk(done == 1'b0, "R1 done after reset", int'(done), 0);
      chk(rf_we == 1'b0, "R1 rf_we after reset", int'(rf_we), 0);
      chk(cr_we == 1'b0, "R1 cr_we after reset", int'(cr_we), 0);
      chk(vl_out == '0, "R1 vl_out after reset", int'(vl_out), 0);
   endtask

   task automatic t_ff_all_pass();
      for (int i = 0; i < MAXVL; i++) begin a_mem[i] = DW'(i + 1); b_mem[i] = DW'(i); end
      run_case("ff_all_pass R2 R3 R4", 8, '1, 2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8);
   endtask

   task automatic t_ff_fail_mid();
      for (int i = 0; i < MAXVL; i++) begin a_mem[i] = DW'(i + 1); b_mem[i] = '0; end
      a_mem[5] = 16'd7; b_mem[5] = 16'hFFF9;
      run_case("ff_fail_mid R5", 10, '1, 2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 56);
   endtask

   task automatic t_ff_fail_first();
      for (int i = 0; i < MAXVL; i++) begin a_mem[i] = DW'(i + 2); b_mem[i] = 16'd1; end
      a_mem[0] = 16'd3; b_mem[0] = 16'hFFFD;
      run_case("ff_fail_elem0 R6", 6, '1, 2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8);
      run_case("vl_zero R6", 0, '1, 2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8);
   endtask

   task automatic t_pred_result();
      for (int i = 0; i < MAXVL; i++) begin
         a_mem[i] = (i % 3 == 0) ? DW'(-(i + 1)) : DW'(i + 2);
         b_mem[i] = '0;
      end
      a_mem[4] = 16'h7FFF; b_mem[4] = 16'd1;
      run_case("pred_result R7 R10", 12, 16'hFF7F, 0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8);
      run_case("pred_result_nozero R7", 12, '1, 0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 20);
   endtask

   task automatic t_cond_only();
      for (int i = 0; i < MAXVL; i++) begin a_mem[i] = DW'(i); b_mem[i] = DW'(-i); end
      for (int i = 1; i < MAXVL; i += 2) b_mem[i] = DW'(5);
      run_case("cond_only_pr R8", 9, '1, 0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8);
      for (int i = 0; i < MAXVL; i++) begin a_mem[i] = DW'(-(i + 3)); b_mem[i] = '0; end
      a_mem[4] = '0;
      run_case("cond_only_ff R8", 10, '1, 0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8);
   endtask

   task automatic t_mask();
      for (int i = 0; i < MAXVL; i++) begin a_mem[i] = DW'(i + 1); b_mem[i] = '0; end
      a_mem[3] = '0; a_mem[6] = '0;
      run_case("mask_ff R9", 8, 16'hFFB7, 2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8);
      run_case("mask_pr R9", 8, 16'h00F7, 2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8);
   endtask

   task automatic t_rc_off();
      for (int i = 0; i < MAXVL; i++) begin
         a_mem[i] = (i % 2 == 0) ? DW'(i + 1) : DW'(-(i + 1));
         b_mem[i] = '0;
      end
      a_mem[2] = 16'h7FFF; b_mem[2] = 16'd1;
      run_case("rc_off R12", 16, '1, 1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8);
      run_case("so_bit_test R4", 5, '1, 3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      miscompares++;
      $display("FAIL watchdog expired: actual %0d expected %0d", 1, 0);
      summary();
      $finish;
   end

   initial begin
      for (int i = 0; i < MAXVL; i++) begin a_mem[i] = '0; b_mem[i] = '0; end
      t_reset();
      t_ff_all_pass();
      t_ff_fail_mid();
      t_ff_fail_first();
      t_pred_result();
      t_cond_only();
      t_mask();
      t_rc_off();
      summary();
      $finish;
   end
endmodule